// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Prescaler

This block generates four independent pulse-width modulated outputs, one bit per channel. Software programs it over a simple register bus. Each channel has its own period (counted in prescaled ticks), its own high-time count and its own prescaler code. A shared control word holds one enable bit and one 2-bit prescaler code for each channel. A typical use is dimming a backlight or an indicator LED.

A channel's prescaler turns the core clock into ticks at 1, 8, 64 or 512 clock cycles per tick. The channel counts these ticks from 0 up to one less than its period, then starts again. Its output is high while the count is below the high-time value. A new period or high-time value written while the channel runs is held until the current period ends, so the output never shows a cut-short pulse.

A separate select register can hand each output pin over to an alternate input, which is passed straight through to the pin.

Top module: `pwm4_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and all four outputs are low.
- R2: Offset 0x00 is the control word. Bit n (n = 0..3) enables channel n. Bits 4+2n+1 : 4+2n hold channel n's prescaler code. Both fields read back as written, and all other bits of the word read 0.
- R3: Channel n's configuration word is at offset 0x04 + 4n. Bits 15:0 hold the period in ticks and bits 31:16 hold the high-time count. The word reads back exactly as written.
- R4: An enabled channel with prescaler code 0 advances its count by one every clock cycle and wraps after period−1. Its output is high while the count is below the high-time value and low otherwise.
- R5: Prescaler codes 0, 1, 2 and 3 give one tick every 1, 8, 64 and 512 clock cycles, each measured from the cycle in which the channel is enabled.
- R6: A period field of 0 means a period of 65536 ticks.
- R7: A high-time count of 0 keeps the output low. A high-time count equal to or greater than the period keeps the output high.
- R8: A configuration word written while its channel runs takes effect only at the first tick after the count wraps to 0. Until then the previous period and high-time count stay in force.
- R9: A disabled channel drives its output low from the first cycle after the control write. Its count and prescaler are held at 0. When the channel is enabled again it starts at count 0, and its output already reflects count 0 in the first enabled cycle.
- R10: Offset 0x14 is the select register, with channel n's bit at position 4n. A 1 routes alt_in[n] to pwm_out[n] and a 0 routes the modulator output. All other bits of the register read 0.
- R11: A write to any other offset, including an unaligned one, changes no register. A read from such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| alt_in | input | 4 | Alternate per-channel sources |
| pwm_out | output | 4 | Per-channel output pins |

## Verification
Each output is compared every cycle against a cycle-level model in the bench.

The bench rewrites a configuration word in the middle of a period. A design without the shadow copy would then produce a shortened pulse, or a count that runs past the new period. It disables a channel mid-period and enables it again, which exposes a counter or prescaler that keeps stale state and restarts at the wrong phase.

Prescaler codes 2 and 3 run long enough to cover several wraps. This catches a cascade whose second stage is clocked by the wrong carry. A period of 0 and high-time counts of 0 and above the period probe the wrap-around of period−1 and the comparison at its ends. Writes to unused and unaligned offsets are followed by a full readback, which reveals a decoder that ignores some address bits.

// File: rtl/pwm4_pkg.sv
// Package: shared offsets, field positions and the prescaler code type
// for the four-channel modulator.
package pwm4_pkg;
    localparam int CTRL_OFF   = 0;   // control word offset
    localparam int CFG_BASE   = 4;   // first channel configuration word
    localparam int REG_STRIDE = 4;   // byte distance between words
    localparam int PSC_LSB    = 4;   // first prescaler field in control
    localparam int PSC_W      = 2;   // prescaler field width
    localparam int SEL_STRIDE = 4;   // bit distance in select register

    typedef enum logic [1:0] {
        PSC_DIV1   = 2'd0,
        PSC_DIV8   = 2'd1,
        PSC_DIV64  = 2'd2,
        PSC_DIV512 = 2'd3
    } psc_code_e;
endpackage

// File: rtl/pwm4_regs.sv
// Register file and address decode.
// Assumes byte offsets on bus_addr, full-word writes and one access per
// cycle. Undefined or unaligned offsets are neither written nor read.
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int TB_W   = 16,
    parameter int ADDR_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [2*TB_W-1:0]              wdata,
    output logic [2*TB_W-1:0]              rdata,
    output logic [NCH-1:0]                 en,
    output psc_code_e [NCH-1:0]            code,
    output logic [NCH-1:0][TB_W-1:0]       cfg_tb,
    output logic [NCH-1:0][TB_W-1:0]       cfg_duty,
    output logic [NCH-1:0]                 sel
);
    localparam int DATA_W  = 2 * TB_W;
    localparam int SEL_OFF = CFG_BASE + REG_STRIDE * NCH;

    logic ctrl_hit;
    logic sel_hit;
    logic [NCH-1:0] cfg_hit;

    // Decode the offset into one hit line per register.
    always_comb begin
        ctrl_hit = (addr == ADDR_W'(CTRL_OFF));
        sel_hit  = (addr == ADDR_W'(SEL_OFF));
        for (int n = 0; n < NCH; n++) begin
            cfg_hit[n] = (addr == ADDR_W'(CFG_BASE + REG_STRIDE * n));
        end
    end

    // Update the registers on a write that hits them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= '0;
            code     <= '0;
            cfg_tb   <= '0;
            cfg_duty <= '0;
            sel      <= '0;
        end else if (wr_en) begin
            for (int n = 0; n < NCH; n++) begin
                if (ctrl_hit) begin
                    en[n]   <= wdata[n];
                    code[n] <= psc_code_e'(wdata[PSC_LSB + PSC_W * n +: PSC_W]);
                end
                if (cfg_hit[n]) begin
                    cfg_tb[n]   <= wdata[TB_W-1:0];
                    cfg_duty[n] <= wdata[DATA_W-1:TB_W];
                end
                if (sel_hit) begin
                    sel[n] <= wdata[SEL_STRIDE * n];
                end
            end
        end
    end

    // Return the addressed register, or 0 for an unused offset.
    always_comb begin
        rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (ctrl_hit) begin
                rdata[n] = en[n];
                rdata[PSC_LSB + PSC_W * n +: PSC_W] = code[n];
            end
            if (cfg_hit[n]) begin
                rdata = {cfg_duty[n], cfg_tb[n]};
            end
            if (sel_hit) begin
                rdata[SEL_STRIDE * n] = sel[n];
            end
        end
    end
endmodule

// File: rtl/pwm4_prescaler.sv
// Per-channel prescaler made of two cascaded stages: a divide-by-8
// stage and a divide-by-64 stage.
// Code 0 ticks every cycle, code 1 uses only the first stage, code 2
// uses only the second stage, and code 3 chains both. Both stages are
// held at zero while run is low, so a tick always comes a full ratio
// after enable.
module pwm4_prescaler
    import pwm4_pkg::*;
#(
    parameter int A_W = 3,
    parameter int B_W = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  psc_code_e code,
    output logic      tick
);
    logic [A_W-1:0] a_cnt;
    logic [B_W-1:0] b_cnt;
    logic           a_carry;
    logic           b_step;
    logic           b_carry;

    // Carry chain between the two stages.
    always_comb begin
        a_carry = &a_cnt;
        b_step  = code[0] ? a_carry : 1'b1;
        b_carry = b_step && (&b_cnt);
    end

    // Advance whichever stages the current code uses.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            a_cnt <= '0;
            b_cnt <= '0;
        end else begin
            if (code[0]) begin
                a_cnt <= a_cnt + 1'b1;
            end
            if (code[1] && b_step) begin
                b_cnt <= b_cnt + 1'b1;
            end
        end
    end

    // Pick the tick source for the selected ratio.
    always_comb begin
        case (code)
            PSC_DIV1:  tick = 1'b1;
            PSC_DIV8:  tick = a_carry;
            default:   tick = b_carry;
        endcase
    end
endmodule

// File: rtl/pwm4_channel.sv
// One modulator channel: a tick counter, an active (shadow) copy of
// period and high-time, and the high-time comparison.
// Assumes the configuration inputs may change at any cycle. They are
// copied while the channel is idle and at each wrap to count 0.
module pwm4_channel #(
    parameter int TB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic [TB_W-1:0] cfg_tb,
    input  logic [TB_W-1:0] cfg_duty,
    output logic            pwm,
    output logic [TB_W-1:0] cnt,
    output logic [TB_W-1:0] act_tb,
    output logic [TB_W-1:0] act_duty
);
    logic [TB_W-1:0] last;

    // Final count of the period; a period field of 0 wraps to all ones.
    assign last = act_tb - 1'b1;

    // Count ticks, wrap at the end of the period and reload the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_tb   <= '0;
            act_duty <= '0;
        end else if (!run) begin
            cnt      <= '0;
            act_tb   <= cfg_tb;
            act_duty <= cfg_duty;
        end else if (tick) begin
            if (cnt == last) begin
                cnt      <= '0;
                act_tb   <= cfg_tb;
                act_duty <= cfg_duty;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // The output is high while the count is below the high-time value.
    assign pwm = run && (cnt < act_duty);
endmodule

// File: rtl/pwm4_top.sv
// Top level of the four-channel modulator. It holds the register file,
// one prescaler and one channel per output, and the output select mux.
// Assumes one clock domain and a synchronous active-low reset.
module pwm4_top
    import pwm4_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int TB_W   = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    alt_in,
    output logic [NCH-1:0]    pwm_out
);
    logic [NCH-1:0]           ch_en;
    psc_code_e [NCH-1:0]      ch_code;
    logic [NCH-1:0][TB_W-1:0] ch_cfg_tb;
    logic [NCH-1:0][TB_W-1:0] ch_cfg_duty;
    logic [NCH-1:0]           ch_sel;
    logic [NCH-1:0]           ch_tick;
    logic [NCH-1:0]           ch_pwm;
    logic [NCH-1:0][TB_W-1:0] ch_cnt;
    logic [NCH-1:0][TB_W-1:0] ch_act_tb;
    logic [NCH-1:0][TB_W-1:0] ch_act_duty;

    pwm4_regs #(
        .NCH(NCH), .TB_W(TB_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .en(ch_en), .code(ch_code),
        .cfg_tb(ch_cfg_tb), .cfg_duty(ch_cfg_duty), .sel(ch_sel)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pwm4_prescaler psc_i (
            .clk(clk), .rst_n(rst_n), .run(ch_en[n]), .code(ch_code[n]),
            .tick(ch_tick[n])
        );

        pwm4_channel #(.TB_W(TB_W)) ch_i (
            .clk(clk), .rst_n(rst_n), .run(ch_en[n]), .tick(ch_tick[n]),
            .cfg_tb(ch_cfg_tb[n]), .cfg_duty(ch_cfg_duty[n]),
            .pwm(ch_pwm[n]), .cnt(ch_cnt[n]), .act_tb(ch_act_tb[n]),
            .act_duty(ch_act_duty[n])
        );

        // Route the modulator or the alternate input to the pin.
        assign pwm_out[n] = ch_sel[n] ? alt_in[n] : ch_pwm[n];
    end
endmodule

// File: rtl/pwm4_chk.sv
// Checker for pwm4_top: output routing, the counter range, the shadow
// copy and the disable behaviour, per channel. Bound to the top below.
module pwm4_chk #(
    parameter int NCH  = 4,
    parameter int TB_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NCH-1:0]           en,
    input logic [NCH-1:0]           sel,
    input logic [NCH-1:0]           alt_in,
    input logic [NCH-1:0]           pwm_out,
    input logic [NCH-1:0][TB_W-1:0] cnt,
    input logic [NCH-1:0][TB_W-1:0] act_tb,
    input logic [NCH-1:0][TB_W-1:0] act_duty
);
    for (genvar n = 0; n < NCH; n++) begin : g_chk
        // R10
        alt_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sel[n] |-> (pwm_out[n] == alt_in[n]));

        // R9
        idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[n] && !sel[n]) |-> !pwm_out[n]);

        // R9
        idle_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en[n] |=> (cnt[n] == '0));

        // R4
        cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en[n] |-> (cnt[n] <= TB_W'(act_tb[n] - 1'b1)));

        // R8
        shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en[n] && $past(en[n]) && (cnt[n] != TB_W'(act_tb[n] - 1'b1)))
            |=> $stable(act_tb[n]));

        // R7
        zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en[n] && !sel[n] && act_duty[n] == '0) |-> !pwm_out[n]);
    end
endmodule

bind pwm4_top pwm4_chk #(.NCH(NCH), .TB_W(TB_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(ch_en), .sel(ch_sel), .alt_in(alt_in),
    .pwm_out(pwm_out), .cnt(ch_cnt), .act_tb(ch_act_tb),
    .act_duty(ch_act_duty)
);

// File: tb/pwm4_top_tb_top.sv
`timescale 1ns/1ps
// Bench for pwm4_top: a cycle-level model built from the requirements,
// random configurations from a fixed seed, and directed corner cases.
module pwm4_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  alt_in = '0;
    logic [3:0]  pwm_out;

    int checks = 0;
    int fails = 0;
    string cur_req = "R4";

    // Model state
    bit   m_en [4];
    bit   m_sel [4];
    logic [1:0] m_code [4];
    int   m_tb [4], m_duty [4], m_atb [4], m_aduty [4], m_cnt [4], m_pre [4];

    pwm4_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_in(alt_in),
        .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic int div_of(logic [1:0] c);
        return 1 << (3 * c);
    endfunction

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            v[n] = m_en[n];
            v[4 + 2 * n +: 2] = m_code[n];
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_sel();
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) v[4 * n] = m_sel[n];
        return v;
    endfunction

    task automatic apply_write(logic [7:0] a, logic [31:0] d);
        if (a == 8'h00) begin
            for (int n = 0; n < 4; n++) begin
                m_en[n] = d[n];
                m_code[n] = d[4 + 2 * n +: 2];
            end
        end else if (a == 8'h14) begin
            for (int n = 0; n < 4; n++) m_sel[n] = d[4 * n];
        end else begin
            for (int n = 0; n < 4; n++) begin
                if (a == 8'(4 + 4 * n)) begin
                    m_tb[n] = int'(d[15:0]);
                    m_duty[n] = int'(d[31:16]);
                end
            end
        end
    endtask

    // One clock cycle: compare the outputs, advance the model, take the edge.
    task automatic step();
        #1;
        for (int n = 0; n < 4; n++) begin
            bit e;
            e = m_sel[n] ? alt_in[n] : (m_en[n] && (m_cnt[n] < m_aduty[n]));
            check(pwm_out[n] === e, cur_req, $sformatf("pwm_out[%0d] cnt=%0d", n, m_cnt[n]),
                  longint'(pwm_out[n]), longint'(e));
        end
        for (int n = 0; n < 4; n++) begin
            int last;
            last = ((m_atb[n] == 0) ? 65536 : m_atb[n]) - 1;
            if (!m_en[n]) begin
                m_cnt[n] = 0; m_pre[n] = 0;
                m_atb[n] = m_tb[n]; m_aduty[n] = m_duty[n];
            end else if (m_pre[n] == div_of(m_code[n]) - 1) begin
                m_pre[n] = 0;
                if (m_cnt[n] == last) begin
                    m_cnt[n] = 0;
                    m_atb[n] = m_tb[n]; m_aduty[n] = m_duty[n];
                end else begin
                    m_cnt[n]++;
                end
            end else begin
                m_pre[n]++;
            end
        end
        if (bus_wr_en) apply_write(bus_addr, bus_wdata);
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
        alt_in = 4'($urandom);
    endtask

    task automatic run(int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr_en = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        step();
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string req);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, req, $sformatf("read 0x%02h", a),
              longint'(bus_rdata), longint'(exp));
    endtask

    task automatic read_all(string req);
        rd_chk(8'h00, exp_ctrl(), req);
        for (int n = 0; n < 4; n++)
            rd_chk(8'(4 + 4 * n), {m_duty[n][15:0], m_tb[n][15:0]}, req);
        rd_chk(8'h14, exp_sel(), req);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired during %s", cur_req);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int n = 0; n < 4; n++) begin
            m_en[n] = 0; m_sel[n] = 0; m_code[n] = 0; m_tb[n] = 0; m_duty[n] = 0;
            m_atb[n] = 0; m_aduty[n] = 0; m_cnt[n] = 0; m_pre[n] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check(pwm_out === 4'b0, "R1", "pwm_out after reset", longint'(pwm_out), 0);
        for (int a = 0; a <= 8'h14; a += 4) rd_chk(8'(a), 32'h0, "R1");
        cur_req = "R1";
        run(4);

        // R2: control layout, readback and reserved bits
        wr(8'h00, 32'hFFFF_FFF0);
        rd_chk(8'h00, 32'h0000_0FF0, "R2");
        wr(8'h00, 32'h0000_0000);
        rd_chk(8'h00, 32'h0, "R2");

        // R3: configuration word readback
        wr(8'h08, 32'hABCD_1234);
        rd_chk(8'h08, 32'hABCD_1234, "R3");
        wr(8'h10, 32'h0042_8001);
        rd_chk(8'h10, 32'h0042_8001, "R3");

        // R10: select register layout and routing
        cur_req = "R10";
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, 32'h0000_1111, "R10");
        run(8);
        wr(8'h14, 32'h0);

        // R11: unused and unaligned offsets
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h41, 32'hFFFF_FFFF);
        read_all("R11");
        rd_chk(8'h18, 32'h0, "R11");
        rd_chk(8'h06, 32'h0, "R11");

        // Random rounds: R4/R5 main function, R8 mid-run rewrite, R9 disable
        for (int r = 0; r < 6; r++) begin
            logic [31:0] ctrl;
            logic [3:0]  s;
            int          ch;
            ctrl = 32'h0;
            for (int n = 0; n < 4; n++) begin
                wr(8'(4 + 4 * n), {16'($urandom_range(0, 24)), 16'($urandom_range(1, 20))});
                if (r % 2 == 1) ctrl[4 + 2 * n +: 2] = 2'($urandom_range(0, 1));
            end
            s = 4'($urandom) & 4'($urandom);
            wr(8'h14, {3'b0, s[3], 3'b0, s[2], 3'b0, s[1], 3'b0, s[0]});
            cur_req = (r % 2 == 1) ? "R5" : "R4";
            wr(8'h00, ctrl | 32'hF);
            run(150);
            cur_req = "R8";
            ch = $urandom_range(0, 3);
            wr(8'(4 + 4 * ch), {16'($urandom_range(0, 24)), 16'($urandom_range(1, 20))});
            run(150);
            cur_req = "R9";
            wr(8'h00, ctrl);
            run(5);
        end
        wr(8'h14, 32'h0);

        // Directed: long prescaler ratios, period 0 and high time >= period
        wr(8'h04, {16'd1, 16'd3});
        wr(8'h08, {16'd1, 16'd2});
        wr(8'h0C, {16'd2, 16'd0});
        wr(8'h10, {16'd9, 16'd5});
        cur_req = "R6";
        wr(8'h00, 32'h0000_00EF);
        run(300);
        cur_req = "R7";
        run(300);
        cur_req = "R5";
        run(1200);
        read_all("R5");

        // Directed: disable mid-period, re-enable, high time 0
        cur_req = "R9";
        wr(8'h00, 32'h0);
        wr(8'h04, {16'd4, 16'd10});
        wr(8'h10, {16'd0, 16'd4});
        wr(8'h00, 32'h0000_0009);
        run(7);
        wr(8'h00, 32'h0000_0008);
        run(3);
        wr(8'h00, 32'h0000_0009);
        run(30);
        cur_req = "R7";
        run(10);

        summary();
        $finish;
    end
endmodule